// File: doc/BRIEF.md
# Pseudo-Static RAM Power-State Sequencer

This block owns the deep-sleep control line of a pseudo-static RAM (the second chip enable, active high) and follows the memory through its power states: the wait after power is applied, normal operation (where ordinary standby is left to the access logic), deep power-down, and the recovery wait after leaving deep power-down. The host asks for deep sleep with `sleep_req` and for a return with `wake_req`. The block raises `ready` only while accesses are allowed, and it passes access requests through as grants only then.

Deep power-down destroys the array contents, so the block raises a sticky `data_lost` flag on every entry into that state. The host clears it with `lost_ack` once it has restored or discarded its data. All waits are clock-cycle counts computed at elaboration from the clock frequency and the wait times in nanoseconds, rounded up. A sleep request made during either wait is remembered, so no wait is ever cut short. A wake request made before the minimum low time has passed is also remembered.

Top module: `psram_pwr_seq`

## Requirements
- R1: After reset release, `ce2_o` is 1 and `ready` is 0 for exactly PU cycles, where PU = ceil(PWRUP_NS × CLK_HZ / 10^9). `ready` reads 1 after the PU-th rising edge. `data_lost` is 0 out of reset.
- R2: When `sleep_req` is 1 at a rising edge while `ready` is 1, both `ce2_o` and `ready` read 0 after that edge.
- R3: Once `ce2_o` falls, it stays 0 for at least M = ceil(DPD_MIN_NS × CLK_HZ / 10^9) cycles. A `wake_req` pulse given earlier is remembered, and `ce2_o` returns to 1 after the edge that completes M low cycles. A `wake_req` given later raises `ce2_o` after the edge that samples it.
- R4: After `ce2_o` rises, `ready` stays 0 for exactly W = ceil(WAKE_NS × CLK_HZ / 10^9) cycles and then reads 1.
- R5: `data_lost` reads 1 after the edge at which `ce2_o` is driven low.
- R6: `data_lost` is cleared only by `lost_ack` sampled while `ready` is 1. `lost_ack` at any other time has no effect. If entry into deep power-down happens at the same edge as an acknowledge, the flag stays set.
- R7: A `sleep_req` sampled during the power-up or wake-up wait is held. When that wait ends, `ce2_o` goes low at once and `ready` never reads 1.
- R8: `acc_grant` equals `acc_req` AND `ready` at all times.
- R9: `wake_req` has no effect outside deep power-down, and `sleep_req` has no effect inside it. A sleep request given in deep power-down does not send the device back to sleep after the wake-up.
- R10: `ready` is 1 only in the active state. It reads 0 throughout power-up, deep power-down and wake-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, frequency CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset; its release starts the power-up wait |
| sleep_req | input | 1 | Host request to enter deep power-down |
| wake_req | input | 1 | Host request to leave deep power-down |
| lost_ack | input | 1 | Host acknowledge that clears `data_lost` |
| acc_req | input | 1 | Access request from the host side |
| ce2_o | output | 1 | Deep-sleep control line to the memory (0 = deep power-down) |
| ready | output | 1 | Accesses are allowed |
| data_lost | output | 1 | Sticky flag: memory contents were lost |
| acc_grant | output | 1 | Access request passed through while ready |

## Verification
The bench checks the exact length of each wait, counting every cycle. An off-by-one counter would show up as `ready` rising one cycle early or late, or as `ce2_o` low for M±1 cycles. It also gives a wake request right after the device enters deep power-down. A design that did not remember that request would stay asleep, and one that did not enforce the minimum low time would raise `ce2_o` at once. A sleep request given during the wake-up wait must produce a direct return to deep power-down with no `ready` pulse. Acknowledges given while not ready, and acknowledges that coincide with sleep entry, must leave `data_lost` set. Random request traffic is then compared cycle by cycle against a bench model of the requirements.

// File: rtl/psram_pwr_pkg.sv
package psram_pwr_pkg;

   typedef enum logic [1:0] {
      PS_PWRUP  = 2'd0,
      PS_ACTIVE = 2'd1,
      PS_DEEP   = 2'd2,
      PS_WAKE   = 2'd3
   } pwr_state_t;

   // index of each remembered request in the hold vector
   localparam int HOLD_SLEEP = 0;
   localparam int HOLD_WAKE  = 1;
   localparam int NUM_HOLDS  = 2;

   // ceil(ns * hz / 1e9)
   function automatic longint unsigned ns_to_cycles(longint unsigned hz,
                                                    longint unsigned ns);
      return (hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
   endfunction

endpackage

// File: rtl/pps_timer.sv
module pps_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   output logic [CW-1:0] cnt
);
   localparam logic [CW-1:0] TOP = {CW{1'b1}};

   initial begin
      assert (CW >= 1) else $error("pps_timer: CW must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (restart)
         cnt <= '0;
      else if (cnt != TOP)
         cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/pps_hold.sv
module pps_hold (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= 1'b0;
      else if (clr)
         q <= 1'b0;
      else if (set)
         q <= 1'b1;
   end
endmodule

// File: rtl/pps_fsm.sv
module pps_fsm
   import psram_pwr_pkg::*;
#(
   parameter int unsigned PU_CYC = 10000,
   parameter int unsigned DM_CYC = 50,
   parameter int unsigned WK_CYC = 10000,
   parameter int          CW     = 14
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sleep_req,
   input  logic                 wake_req,
   input  logic                 lost_ack,
   input  logic [NUM_HOLDS-1:0] hold_q,
   input  logic [CW-1:0]        tmr_cnt,
   output logic                 tmr_restart,
   output logic [NUM_HOLDS-1:0] hold_set,
   output logic [NUM_HOLDS-1:0] hold_clr,
   output logic                 ce2_o,
   output logic                 ready,
   output logic                 data_lost
);
   localparam logic [CW-1:0] PU_LAST = CW'(PU_CYC - 1);
   localparam logic [CW-1:0] DM_LAST = CW'(DM_CYC - 1);
   localparam logic [CW-1:0] WK_LAST = CW'(WK_CYC - 1);

   initial begin
      assert (PU_CYC >= 1 && DM_CYC >= 1 && WK_CYC >= 1)
         else $error("pps_fsm: every wait needs at least one cycle");
      assert ((1 << CW) > PU_CYC && (1 << CW) > DM_CYC && (1 << CW) > WK_CYC)
         else $error("pps_fsm: counter too narrow for the waits");
   end

   pwr_state_t state, nxt;
   logic sleep_any, wake_any, leaving;

   assign sleep_any = sleep_req | hold_q[HOLD_SLEEP];
   assign wake_any  = wake_req  | hold_q[HOLD_WAKE];

   always_comb begin
      nxt = state;
      unique case (state)
         PS_PWRUP:  if (tmr_cnt == PU_LAST) nxt = sleep_any ? PS_DEEP : PS_ACTIVE;
         PS_ACTIVE: if (sleep_req) nxt = PS_DEEP;
         PS_DEEP:   if (wake_any && tmr_cnt >= DM_LAST) nxt = PS_WAKE;
         PS_WAKE:   if (tmr_cnt == WK_LAST) nxt = sleep_any ? PS_DEEP : PS_ACTIVE;
         default:   nxt = PS_PWRUP;
      endcase
   end

   assign leaving     = (nxt != state);
   assign tmr_restart = leaving;

   always_comb begin
      hold_set = '0;
      hold_clr = '0;
      hold_set[HOLD_SLEEP] = sleep_req && !leaving &&
                             (state == PS_PWRUP || state == PS_WAKE);
      hold_set[HOLD_WAKE]  = wake_req && !leaving && (state == PS_DEEP);
      hold_clr[HOLD_SLEEP] = leaving;
      hold_clr[HOLD_WAKE]  = leaving;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= PS_PWRUP;
         ce2_o     <= 1'b1;
         ready     <= 1'b0;
         data_lost <= 1'b0;
      end else begin
         state <= nxt;
         ce2_o <= (nxt != PS_DEEP);
         ready <= (nxt == PS_ACTIVE);
         if (nxt == PS_DEEP && state != PS_DEEP)
            data_lost <= 1'b1;
         else if (lost_ack && state == PS_ACTIVE)
            data_lost <= 1'b0;
      end
   end

   // R2: an accepted sleep drops readiness and the control line together
   a_r2_sleep_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && sleep_req) |=> (!ready && !ce2_o));

   // R3: the line never rises before the minimum low time
   a_r3_min_low: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce2_o && state == PS_DEEP && tmr_cnt < DM_LAST) |=> !ce2_o);

   // R4: no readiness in the cycle after the line rises
   a_r4_wake_wait: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ce2_o) |-> !ready);

   // R5: loss flag accompanies every entry into deep power-down
   a_r5_lost_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ce2_o) |-> data_lost);

   // R6: the flag stays set without an acknowledge while ready
   a_r6_lost_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (data_lost && !(lost_ack && ready)) |=> data_lost);

   // R10: readiness implies the device is not in deep power-down
   a_r10_ready_awake: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> ce2_o);

endmodule

// File: rtl/psram_pwr_seq.sv
module psram_pwr_seq
   import psram_pwr_pkg::*;
#(
   parameter int unsigned CLK_HZ     = 50_000_000,
   parameter int unsigned PWRUP_NS   = 200_000,
   parameter int unsigned WAKE_NS    = 200_000,
   parameter int unsigned DPD_MIN_NS = 1_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep_req,
   input  logic wake_req,
   input  logic lost_ack,
   input  logic acc_req,
   output logic ce2_o,
   output logic ready,
   output logic data_lost,
   output logic acc_grant
);
   localparam longint unsigned PU_L = ns_to_cycles(64'(CLK_HZ), 64'(PWRUP_NS));
   localparam longint unsigned WK_L = ns_to_cycles(64'(CLK_HZ), 64'(WAKE_NS));
   localparam longint unsigned DM_L = ns_to_cycles(64'(CLK_HZ), 64'(DPD_MIN_NS));
   localparam longint unsigned MX_A = (PU_L > WK_L) ? PU_L : WK_L;
   localparam longint unsigned MX_L = (MX_A > DM_L) ? MX_A : DM_L;
   localparam int              CW   = $clog2(MX_L + 1);

   initial begin
      assert (CLK_HZ > 0) else $error("psram_pwr_seq: CLK_HZ must be nonzero");
      assert (MX_L < 64'h8000_0000) else $error("psram_pwr_seq: wait too long");
   end

   logic                 tmr_restart;
   logic [CW-1:0]        tmr_cnt;
   logic [NUM_HOLDS-1:0] hold_set, hold_clr, hold_q;

   pps_timer #(.CW(CW)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (tmr_restart),
      .cnt     (tmr_cnt)
   );

   for (genvar g = 0; g < NUM_HOLDS; g++) begin : g_hold
      pps_hold u_hold (
         .clk   (clk),
         .rst_n (rst_n),
         .set   (hold_set[g]),
         .clr   (hold_clr[g]),
         .q     (hold_q[g])
      );
   end

   pps_fsm #(
      .PU_CYC (32'(PU_L)),
      .DM_CYC (32'(DM_L)),
      .WK_CYC (32'(WK_L)),
      .CW     (CW)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .sleep_req   (sleep_req),
      .wake_req    (wake_req),
      .lost_ack    (lost_ack),
      .hold_q      (hold_q),
      .tmr_cnt     (tmr_cnt),
      .tmr_restart (tmr_restart),
      .hold_set    (hold_set),
      .hold_clr    (hold_clr),
      .ce2_o       (ce2_o),
      .ready       (ready),
      .data_lost   (data_lost)
   );

   assign acc_grant = acc_req & ready;

endmodule

// File: tb/psram_pwr_seq_bench.sv
module psram_pwr_seq_bench;
   localparam int unsigned HZ  = 50_000_000;
   localparam int unsigned PNS = 2000;
   localparam int unsigned WNS = 1000;
   localparam int unsigned MNS = 290;

   function automatic int cyc_of(longint unsigned ns);
      longint unsigned p;
      p = 64'(HZ) * ns;
      return int'((p + 64'd999_999_999) / 64'd1_000_000_000);
   endfunction

   localparam int PU = 100;   // 2000 ns at 50 MHz
   localparam int W  = 50;    // 1000 ns
   localparam int M  = 15;    // 290 ns rounds up to 14.5 -> 15

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sleep_req = 0, wake_req = 0, lost_ack = 0, acc_req = 0;
   logic ce2_o, ready, data_lost, acc_grant;

   always #10 clk = ~clk;

   psram_pwr_seq #(.CLK_HZ(HZ), .PWRUP_NS(PNS), .WAKE_NS(WNS), .DPD_MIN_NS(MNS))
      u_psram_pwr_seq (.clk(clk), .rst_n(rst_n), .sleep_req(sleep_req),
                       .wake_req(wake_req), .lost_ack(lost_ack), .acc_req(acc_req),
                       .ce2_o(ce2_o), .ready(ready), .data_lost(data_lost),
                       .acc_grant(acc_grant));

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   // bench model: 0 power-up, 1 active, 2 deep, 3 wake
   int ms = 0, mc = 0;
   bit msp = 0, mwp = 0, mlost = 0;

   task automatic chk(string tag, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_edge(bit sl, bit wk, bit ak);
      int nx;
      nx = ms;
      case (ms)
         0: if (mc == PU-1) nx = (sl || msp) ? 2 : 1;
         1: if (sl) nx = 2;
         2: if ((wk || mwp) && mc >= M-1) nx = 3;
         default: if (mc == W-1) nx = (sl || msp) ? 2 : 1;
      endcase
      if (nx == 2 && ms != 2) mlost = 1;
      else if (ak && ms == 1) mlost = 0;
      if (nx != ms) begin msp = 0; mwp = 0; mc = 0; end
      else begin
         if (sl && (ms == 0 || ms == 3)) msp = 1;
         if (wk && ms == 2) mwp = 1;
         mc++;
      end
      ms = nx;
   endtask

   task automatic step(bit sl, bit wk, bit ak, bit ac);
      sleep_req = sl; wake_req = wk; lost_ack = ak; acc_req = ac;
      @(posedge clk);
      model_edge(sl, wk, ak);
      @(negedge clk);
      chk("R2 ce2 vs model", ce2_o, ms != 2);
      chk("R10 ready vs model", ready, ms == 1);
      chk("R5 data_lost vs model", data_lost, mlost);
      chk("R8 grant", acc_grant, ac && (ms == 1));
   endtask

   initial begin
      int lowc, waitc;
      void'($urandom(32'h5eed_1234));
      chk("R1 wait length", 1'b1, (cyc_of(PNS) == PU) && (cyc_of(WNS) == W) && (cyc_of(MNS) == M));
      #15;
      chk("R1 reset ce2", ce2_o, 1'b1);
      chk("R1 reset ready", ready, 1'b0);
      chk("R1 reset lost", data_lost, 1'b0);
      @(negedge clk); rst_n = 1'b1;
      // R1: power-up length, R8 grant blocked meanwhile
      for (int i = 0; i < PU-1; i++) step(0, 0, 0, 1);
      chk("R1 not ready before PU", ready, 1'b0);
      step(0, 0, 0, 1);
      chk("R1 ready at PU", ready, 1'b1);
      chk("R8 grant when ready", acc_grant, 1'b1);
      // R9: wake while active ignored
      step(0, 1, 0, 0);
      chk("R9 wake in active", ce2_o, 1'b1);
      // R2 / R5
      step(1, 0, 0, 0);
      chk("R2 ce2 low", ce2_o, 1'b0);
      chk("R2 ready low", ready, 1'b0);
      chk("R5 lost set", data_lost, 1'b1);
      // R3: early wake remembered; R6 ack while asleep ignored; R9 sleep in deep
      lowc = 1;
      step(0, 1, 1, 0);
      if (!ce2_o) lowc++;
      chk("R6 ack in deep ignored", data_lost, 1'b1);
      step(1, 0, 0, 0);
      if (!ce2_o) lowc++;
      for (int i = 0; i < 40 && !ce2_o; i++) begin
         step(0, 0, 0, 0);
         if (!ce2_o) lowc++;
      end
      chk("R3 low exactly M", 1'b1, lowc == M);
      // R4: wake wait length
      waitc = 1;
      for (int i = 0; i < 200 && !ready; i++) begin
         step(0, 0, 0, 0);
         if (!ready) waitc++;
      end
      chk("R4 wake wait W", 1'b1, waitc == W);
      chk("R9 sleep in deep no effect", ce2_o, 1'b1);
      chk("R6 still lost after wake", data_lost, 1'b1);
      step(0, 0, 1, 0);
      chk("R6 ack while ready clears", data_lost, 1'b0);
      // R6: ack coinciding with entry keeps flag set
      step(1, 0, 1, 0);
      chk("R6 entry wins over ack", data_lost, 1'b1);
      // late wake after min time: rises at once
      for (int i = 0; i < M + 3; i++) step(0, 0, 0, 0);
      step(0, 1, 0, 0);
      chk("R3 late wake rises next edge", ce2_o, 1'b1);
      // R7: sleep during wake is held
      step(0, 0, 1, 0);
      step(1, 0, 0, 0);
      waitc = 0;
      for (int i = 0; i < 200 && ce2_o; i++) begin
         step(0, 0, 0, 1);
         if (ready) waitc++;
      end
      chk("R7 back to deep", ce2_o, 1'b0);
      chk("R7 ready never high", 1'b1, waitc == 0);
      // random phase against the model
      for (int i = 0; i < 6000; i++)
         step(($urandom % 40) == 0, ($urandom % 8) == 0,
              ($urandom % 16) == 0, ($urandom % 2) == 0);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule